// File: doc/BRIEF.md
# Multi-line tagged serial receive buffer

This block deserializes characters arriving on several asynchronous serial input lines and merges them into one shared first-in first-out buffer. Every stored entry is a 16-bit word. It carries a valid bit, the number of the line that delivered the character, separate overrun, framing and parity flags, and the character itself. Software drains the buffer by reading the word and pulsing a read strobe. It repeats this until the valid bit reads back as zero.

Each line has its own parameter register, written through one shared write port whose low bits pick the line. The register sets the character length, one or two stop bits, parity on or off, odd or even parity, a 4-bit rate code and a receiver-enable bit. An external per-line tick runs at sixteen times the bit rate. The rate code is passed out so that the tick source can use it. A break on the line appears as a zero character with the framing flag set. There is no separate break flag. A receive interrupt is raised while data is waiting and interrupts are enabled.

Top module: `tagged_rx_buf`

## Requirements
- R1: After reset the read word, the interrupt, the status word and every line's rate code are all zero, and every receiver is disabled.
- R2: The read word is laid out as bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:8 line number and bits 7:0 character. Entries leave in the order they were stored, and a read strobe removes the oldest one.
- R3: Character length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, sent least significant bit first. The stored character is right-justified and its unused upper bits read as zero.
- R4: With parity enabled, one parity bit follows the data. It is even parity when the odd bit is 0 and odd parity when the odd bit is 1. A mismatch sets the parity flag, and the character is still stored.
- R5: A low first stop bit sets the framing flag. A line held low through a whole frame yields exactly one entry, with a zero character and the framing flag, and no further entry until the line has returned high.
- R6: A line whose receiver-enable bit is clear adds nothing to the buffer.
- R7: The interrupt is high exactly when the interrupt-enable bit is set and the buffer is not empty. The status word shows receive-done (buffer not empty) in bit 7 and the interrupt-enable bit in bit 6.
- R8: The buffer holds 16 entries. A character that completes while the buffer is full is discarded. The next entry stored afterwards carries the overrun flag, and later entries do not.
- R9: Characters that complete in the same cycle on several lines are stored lowest line number first.
- R10: A parameter write changes only the line named in data bits 3:0. The other fields sit at bits 5:4 length, 6 two stop bits, 7 parity enable, 8 odd, 12:9 rate code and 13 receiver enable. Each line's rate code appears on its own 4-bit slice of the rate output.
- R11: In two-stop-bit mode both stop bits are sampled, and a low level on either one sets the framing flag.
- R12: While the buffer is empty the read word is all zeros, and a read strobe has no effect on later contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | NLINES | Per-line sample tick at sixteen times the bit rate |
| rx_i | input | NLINES | Serial inputs, idle high |
| lpr_we_i | input | 1 | Line parameter write strobe |
| lpr_wdata_i | input | 14 | Line parameter write data (line select in bits 3:0) |
| csr_we_i | input | 1 | Interrupt-enable write strobe |
| csr_rie_i | input | 1 | Interrupt-enable value to write |
| csr_rdata_o | output | 16 | Status word: bit 7 receive-done, bit 6 interrupt enable |
| rbuf_rd_i | input | 1 | Read strobe: removes the oldest entry |
| rbuf_o | output | 16 | Oldest entry, or zero when empty |
| rx_irq_o | output | 1 | Receive interrupt |
| baud_o | output | 4*NLINES | Rate code of each line |

## Verification
The bench targets four kinds of error. The first is frames that end in the same cycle on all lines; a wrong arbiter would lose or reorder entries. The second is a frame that arrives into a full buffer; a careless overrun path would store it, lose the flag, or leave the flag set on every later entry. The third is a line held low for a long break; a receiver that does not wait for the line to go high would post a stream of zero characters. Short characters, odd and even parity errors and disabled lines are also driven: a wrong right-justification would show stray upper bits, an inverted parity sense would flag good frames, and a missing enable gate would let entries from a disabled line into the buffer.

// File: rtl/trb_pkg.sv
package trb_pkg;

    localparam int WORD_W       = 16;
    localparam int LINE_FW      = 4;
    localparam int CHAR_W       = 8;
    localparam int LPR_W        = 14;
    localparam int CSR_RIE_BIT  = 6;
    localparam int CSR_DONE_BIT = 7;

    typedef struct packed {
        logic       rxen;
        logic [3:0] baud;
        logic       odd;
        logic       paren;
        logic       stop2;
        logic [1:0] csize;
    } line_cfg_t;

    typedef struct packed {
        logic               oe;
        logic               fe;
        logic               pe;
        logic [LINE_FW-1:0] line;
        logic [CHAR_W-1:0]  ch;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_DATA,
        RS_PAR,
        RS_STOP,
        RS_STOP2,
        RS_WAIT_HI
    } rx_state_t;

    function automatic line_cfg_t lpr_decode(input logic [LPR_W-1:0] w);
        line_cfg_t c;
        c.csize = w[5:4];
        c.stop2 = w[6];
        c.paren = w[7];
        c.odd   = w[8];
        c.baud  = w[12:9];
        c.rxen  = w[13];
        return c;
    endfunction

    function automatic logic [3:0] char_bits(input logic [1:0] cs);
        return 4'd5 + {2'b00, cs};
    endfunction

    function automatic logic [CHAR_W-1:0] right_justify(input logic [CHAR_W-1:0] sh,
                                                        input logic [1:0] cs);
        return sh >> (2'd3 - cs);
    endfunction

    function automatic logic [WORD_W-1:0] rbuf_word(input logic v, input rx_entry_t e);
        return v ? {1'b1, e} : '0;
    endfunction

endpackage

// File: rtl/trb_line_rx.sv
module trb_line_rx
    import trb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        csize,
    input  logic              paren,
    input  logic              odd,
    input  logic              stop2,
    input  logic              rxen,
    input  logic              ack,
    output logic              hold_vld,
    output logic [CHAR_W-1:0] hold_ch,
    output logic              hold_fe,
    output logic              hold_pe
);

    logic [1:0]        sync_q;
    logic              rxs;
    rx_state_t         st_q;
    logic [3:0]        ph_q;
    logic [2:0]        bit_q;
    logic [CHAR_W-1:0] sh_q;
    logic              par_q;
    logic              perr_q;
    logic              fe_q;
    logic [2:0]        last_bit;
    logic              mid;

    assign rxs      = sync_q[1];
    assign last_bit = 3'(char_bits(csize) - 4'd1);
    assign mid      = (ph_q == 4'd15);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= 2'b11;
            st_q     <= RS_IDLE;
            ph_q     <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            par_q    <= 1'b0;
            perr_q   <= 1'b0;
            fe_q     <= 1'b0;
            hold_vld <= 1'b0;
            hold_ch  <= '0;
            hold_fe  <= 1'b0;
            hold_pe  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rx};
            if (ack) hold_vld <= 1'b0;
            if (st_q == RS_WAIT_HI) begin
                if (rxs) st_q <= RS_IDLE;
            end else if (tick) begin
                ph_q <= ph_q + 4'd1;
                case (st_q)
                    RS_IDLE: begin
                        if (!rxs) begin
                            st_q <= RS_START;
                            ph_q <= '0;
                        end
                    end
                    RS_START: begin
                        if (ph_q == 4'd7) begin
                            if (rxs) begin
                                st_q <= RS_IDLE;
                            end else begin
                                st_q   <= RS_DATA;
                                ph_q   <= '0;
                                bit_q  <= '0;
                                par_q  <= 1'b0;
                                perr_q <= 1'b0;
                                fe_q   <= 1'b0;
                            end
                        end
                    end
                    RS_DATA: begin
                        if (mid) begin
                            sh_q  <= {rxs, sh_q[CHAR_W-1:1]};
                            par_q <= par_q ^ rxs;
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == last_bit) st_q <= paren ? RS_PAR : RS_STOP;
                        end
                    end
                    RS_PAR: begin
                        if (mid) begin
                            perr_q <= par_q ^ rxs ^ odd;
                            st_q   <= RS_STOP;
                        end
                    end
                    RS_STOP: begin
                        if (mid) begin
                            if (stop2) begin
                                fe_q <= !rxs;
                                st_q <= RS_STOP2;
                            end else begin
                                if (rxen) begin
                                    hold_vld <= 1'b1;
                                    hold_ch  <= right_justify(sh_q, csize);
                                    hold_fe  <= !rxs;
                                    hold_pe  <= perr_q;
                                end
                                st_q <= rxs ? RS_IDLE : RS_WAIT_HI;
                            end
                        end
                    end
                    RS_STOP2: begin
                        if (mid) begin
                            if (rxen) begin
                                hold_vld <= 1'b1;
                                hold_ch  <= right_justify(sh_q, csize);
                                hold_fe  <= fe_q | !rxs;
                                hold_pe  <= perr_q;
                            end
                            st_q <= rxs ? RS_IDLE : RS_WAIT_HI;
                        end
                    end
                    default: st_q <= RS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/trb_fifo.sv
module trb_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tagged_rx_buf.sv
module tagged_rx_buf
    import trb_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int DEPTH  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NLINES-1:0]   tick_i,
    input  logic [NLINES-1:0]   rx_i,
    input  logic                lpr_we_i,
    input  logic [LPR_W-1:0]    lpr_wdata_i,
    input  logic                csr_we_i,
    input  logic                csr_rie_i,
    output logic [WORD_W-1:0]   csr_rdata_o,
    input  logic                rbuf_rd_i,
    output logic [WORD_W-1:0]   rbuf_o,
    output logic                rx_irq_o,
    output logic [4*NLINES-1:0] baud_o
);

    localparam int CW    = $clog2(DEPTH + 1);
    localparam int ENT_W = $bits(rx_entry_t);

    line_cfg_t         cfg_q [NLINES];
    logic [NLINES-1:0] req;
    logic [NLINES-1:0] grant;
    logic [NLINES-1:0] hfe;
    logic [NLINES-1:0] hpe;
    logic [CHAR_W-1:0] hch [NLINES];
    rx_entry_t         sel_entry;
    rx_entry_t         head;
    logic              push_any;
    logic              fifo_push;
    logic              fifo_pop;
    logic              drop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CW-1:0]     fifo_count;
    logic              ovr_pend_q;
    logic              rie_q;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (lpr_we_i && (lpr_wdata_i[LINE_FW-1:0] == LINE_FW'(g))) begin
                cfg_q[g] <= lpr_decode(lpr_wdata_i);
            end
        end

        assign baud_o[4*g +: 4] = cfg_q[g].baud;

        trb_line_rx u_rx (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_i[g]),
            .rx       (rx_i[g]),
            .csize    (cfg_q[g].csize),
            .paren    (cfg_q[g].paren),
            .odd      (cfg_q[g].odd),
            .stop2    (cfg_q[g].stop2),
            .rxen     (cfg_q[g].rxen),
            .ack      (grant[g]),
            .hold_vld (req[g]),
            .hold_ch  (hch[g]),
            .hold_fe  (hfe[g]),
            .hold_pe  (hpe[g])
        );
    end

    // Fixed priority: the lowest numbered line with a finished character wins.
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        sel_entry = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (req[i] && !found) begin
                found          = 1'b1;
                grant[i]       = 1'b1;
                sel_entry.line = LINE_FW'(i);
                sel_entry.ch   = hch[i];
                sel_entry.fe   = hfe[i];
                sel_entry.pe   = hpe[i];
            end
        end
        sel_entry.oe = ovr_pend_q;
    end

    assign push_any  = |req;
    assign fifo_push = push_any && !fifo_full;
    assign drop      = push_any && fifo_full;
    assign fifo_pop  = rbuf_rd_i && !fifo_empty;

    trb_fifo #(
        .DEPTH (DEPTH),
        .W     (ENT_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (sel_entry),
        .pop   (fifo_pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_pend_q <= 1'b0;
            rie_q      <= 1'b0;
        end else begin
            if (fifo_push)  ovr_pend_q <= 1'b0;
            else if (drop)  ovr_pend_q <= 1'b1;
            if (csr_we_i)   rie_q <= csr_rie_i;
        end
    end

    always_comb begin
        csr_rdata_o               = '0;
        csr_rdata_o[CSR_DONE_BIT] = !fifo_empty;
        csr_rdata_o[CSR_RIE_BIT]  = rie_q;
    end

    assign rbuf_o   = rbuf_word(!fifo_empty, head);
    assign rx_irq_o = rie_q && !fifo_empty;

endmodule

// File: rtl/trb_checker.sv
module trb_checker #(
    parameter int NLINES = 4,
    parameter int DEPTH  = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rbuf_valid,
    input logic                       rx_irq,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       fifo_push,
    input logic                       fifo_pop,
    input logic                       drop,
    input logic                       ovr_pend,
    input logic [NLINES-1:0]          req,
    input logic [NLINES-1:0]          grant
);

    localparam int CW = $clog2(DEPTH + 1);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!rbuf_valid && !rx_irq)); // R1

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && !fifo_pop) |=> (count == $past(count) + CW'(1))); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop && !fifo_push) |=> (count == $past(count) - CW'(1))); // R2

    AST_NO_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !rbuf_valid |-> !rx_irq); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R8

    AST_DROP_MARKS: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovr_pend); // R8

    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> !ovr_pend); // R8

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R9

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((req & (grant - NLINES'(1))) == '0)); // R9

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !rbuf_valid); // R12

endmodule

bind tagged_rx_buf trb_checker #(
    .NLINES (NLINES),
    .DEPTH  (DEPTH)
) u_trb_checker (
    .clk        (clk),
    .rst        (rst),
    .rbuf_valid (rbuf_o[15]),
    .rx_irq     (rx_irq_o),
    .count      (fifo_count),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .drop       (drop),
    .ovr_pend   (ovr_pend_q),
    .req        (req),
    .grant      (grant)
);

// File: tb/tagged_rx_buf_bench.sv
module tagged_rx_buf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 4;
    localparam int DEP        = 16;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CYC    = TICK_DIV * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] tick_i = '0;
    logic [NL-1:0] rx_i = '1;
    logic          lpr_we_i = 1'b0;
    logic [13:0]   lpr_wdata_i = '0;
    logic          csr_we_i = 1'b0;
    logic          csr_rie_i = 1'b0;
    logic [15:0]   csr_rdata_o;
    logic          rbuf_rd_i = 1'b0;
    logic [15:0]   rbuf_o;
    logic          rx_irq_o;
    logic [4*NL-1:0] baud_o;

    tagged_rx_buf #(.NLINES(NL), .DEPTH(DEP)) u_tagged_rx_buf (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rx_i(rx_i),
        .lpr_we_i(lpr_we_i), .lpr_wdata_i(lpr_wdata_i),
        .csr_we_i(csr_we_i), .csr_rie_i(csr_rie_i), .csr_rdata_o(csr_rdata_o),
        .rbuf_rd_i(rbuf_rd_i), .rbuf_o(rbuf_o), .rx_irq_o(rx_irq_o), .baud_o(baud_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    bit quiet = 0;

    // reference model state
    logic [15:0] exp_q[$];
    bit          ovr_m = 0;
    bit          rie_m = 0;
    int          nb_m[NL];
    bit          par_m[NL], odd_m[NL], st2_m[NL], rxen_m[NL];
    logic [3:0]  baud_m[NL];

    // per-frame stimulus
    logic [7:0] tx_ch[NL];
    bit         tx_badpar[NL], tx_badstop[NL], tx_brk[NL];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        int tdiv = 0;
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % TICK_DIV;
            tick_i = (tdiv == 0) ? '1 : '0;
        end
    end

    // every-clock comparison against the model once the lines are idle
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (quiet) begin
                chk("R2 head", rbuf_o, (exp_q.size() != 0) ? exp_q[0] : 16'h0);
                chk("R7 irq", rx_irq_o, rie_m && (exp_q.size() != 0));
            end
        end
    end

    function automatic logic [7:0] cmask(input int nb);
        return 8'((1 << nb) - 1);
    endfunction

    function automatic int flen(input int l);
        return 2 + nb_m[l] + int'(par_m[l]) + int'(st2_m[l]);
    endfunction

    function automatic logic fbit(input int l, input int b);
        int idx;
        if (tx_brk[l]) return (b < 2 * flen(l)) ? 1'b0 : 1'b1;
        if (b == 0) return 1'b0;
        if (b <= nb_m[l]) return tx_ch[l][b-1];
        idx = nb_m[l] + 1;
        if (par_m[l]) begin
            if (b == idx) return (^(tx_ch[l] & cmask(nb_m[l]))) ^ odd_m[l] ^ tx_badpar[l];
            idx++;
        end
        if (b == idx) return !tx_badstop[l];
        return 1'b1;
    endfunction

    task automatic wr_lpr(input int l, input int cs, input bit st2, input bit par,
                          input bit odd, input logic [3:0] baud, input bit en);
        @(negedge clk);
        lpr_we_i = 1'b1;
        lpr_wdata_i = {en, baud, odd, par, st2, 2'(cs), 4'(l)};
        @(posedge clk);
        nb_m[l] = 5 + cs; st2_m[l] = st2; par_m[l] = par; odd_m[l] = odd;
        baud_m[l] = baud; rxen_m[l] = en;
        @(negedge clk);
        lpr_we_i = 1'b0;
    endtask

    task automatic wr_rie(input bit v);
        @(negedge clk);
        csr_we_i = 1'b1; csr_rie_i = v;
        @(posedge clk);
        rie_m = v;
        @(negedge clk);
        csr_we_i = 1'b0;
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        chk(tag, rbuf_o, (exp_q.size() != 0) ? exp_q[0] : 16'h0);
        rbuf_rd_i = 1'b1;
        @(posedge clk);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        @(negedge clk);
        rbuf_rd_i = 1'b0;
    endtask

    task automatic clear_tx();
        for (int l = 0; l < NL; l++) begin
            tx_badpar[l] = 0; tx_badstop[l] = 0; tx_brk[l] = 0;
        end
    endtask

    task automatic send(input logic [NL-1:0] mask);
        int total = 0;
        quiet = 0;
        for (int l = 0; l < NL; l++)
            if (mask[l]) total = (tx_brk[l] ? 2 * flen(l) : flen(l)) > total ?
                                 (tx_brk[l] ? 2 * flen(l) : flen(l)) : total;
        for (int b = 0; b < total; b++) begin
            @(negedge clk);
            for (int l = 0; l < NL; l++) rx_i[l] = mask[l] ? fbit(l, b) : 1'b1;
            repeat (BIT_CYC - 1) @(negedge clk);
        end
        @(negedge clk);
        rx_i = '1;
        repeat (2 * BIT_CYC) @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            if (mask[l] && rxen_m[l]) begin
                logic [15:0] w;
                w = {1'b1, ovr_m, tx_badstop[l] | tx_brk[l], par_m[l] & tx_badpar[l] & !tx_brk[l],
                     4'(l), tx_brk[l] ? 8'h00 : (tx_ch[l] & cmask(nb_m[l]))};
                if (exp_q.size() == DEP) ovr_m = 1;
                else begin exp_q.push_back(w); ovr_m = 0; end
            end
        end
        quiet = 1;
    endtask

    initial begin
        clear_tx();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < NL; l++) begin
            nb_m[l] = 5; par_m[l] = 0; odd_m[l] = 0; st2_m[l] = 0; rxen_m[l] = 0; baud_m[l] = 0;
        end
        @(negedge clk);
        chk("R1 rbuf", rbuf_o, 0);
        chk("R1 irq", rx_irq_o, 0);
        chk("R1 csr", csr_rdata_o, 0);
        chk("R1 baud", baud_o, 0);
        quiet = 1;

        // R1: receivers start disabled
        tx_ch[0] = 8'h11;
        send(4'b0001);
        chk("R1 disabled after reset", rbuf_o, 0);

        // R10: per-line configuration
        wr_lpr(0, 3, 0, 0, 0, 4'd14, 1);
        wr_lpr(1, 2, 0, 1, 0, 4'd3, 1);
        wr_lpr(2, 0, 1, 1, 1, 4'd9, 1);
        wr_lpr(3, 1, 0, 0, 0, 4'd5, 0);
        chk("R10 baud", baud_o, {baud_m[3], baud_m[2], baud_m[1], baud_m[0]});

        wr_rie(1);
        chk("R7 csr idle", csr_rdata_o, 16'h0040);

        // R2: 8-bit character on line 0
        tx_ch[0] = 8'hA5;
        send(4'b0001);
        chk("R7 csr pending", csr_rdata_o, 16'h00C0);
        chk("R7 irq pending", rx_irq_o, 1);
        do_read("R2 line0 8bit");

        // R3/R4: 7-bit even parity, upper bit discarded
        tx_ch[1] = 8'hDB;
        send(4'b0010);
        chk("R3 7bit", rbuf_o, 16'h815B);
        tx_badpar[1] = 1; tx_ch[1] = 8'h22;
        send(4'b0010);
        clear_tx();
        do_read("R3 7bit read");
        chk("R4 even parity error", rbuf_o, 16'h9122);
        do_read("R4 even read");

        // R3/R4/R11: 5-bit odd parity, two stop bits
        tx_ch[2] = 8'hF3;
        send(4'b0100);
        chk("R3 5bit odd", rbuf_o, 16'h8213);
        tx_badpar[2] = 1; tx_ch[2] = 8'h0A;
        send(4'b0100);
        clear_tx();
        do_read("R4 odd ok read");
        chk("R4 odd parity error", rbuf_o, 16'h920A);
        do_read("R4 odd read");
        tx_badstop[2] = 1; tx_ch[2] = 8'h05;
        send(4'b0100);
        clear_tx();
        do_read("R11 first stop low");

        // R5: framing error and break
        tx_badstop[0] = 1; tx_ch[0] = 8'h3C;
        send(4'b0001);
        clear_tx();
        do_read("R5 framing");
        tx_brk[0] = 1;
        send(4'b0001);
        clear_tx();
        do_read("R5 break entry");
        do_read("R12 single break entry then empty");
        do_read("R12 read while empty");

        // R6: disabled line stays out of the buffer
        tx_ch[3] = 8'h2A;
        send(4'b1000);
        chk("R6 disabled", rbuf_o, 0);
        wr_lpr(3, 1, 0, 0, 0, 4'd5, 1);
        chk("R10 others kept", baud_o, {4'd5, 4'd9, 4'd3, 4'd14});
        send(4'b1000);
        do_read("R6 enabled 6bit");

        // R9: simultaneous completion, all lines 8N1
        for (int l = 0; l < NL; l++) wr_lpr(l, 3, 0, 0, 0, 4'd14, 1);
        tx_ch[0] = 8'h40; tx_ch[1] = 8'h41; tx_ch[2] = 8'h42; tx_ch[3] = 8'h43;
        send(4'b1111);
        chk("R9 lowest first", rbuf_o, 16'h8040);
        wr_rie(0);
        chk("R7 irq masked", rx_irq_o, 0);
        wr_rie(1);
        for (int k = 0; k < NL; k++) do_read("R9 order");

        // R8: overrun
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < NL; l++) tx_ch[l] = 8'(16 * r + l);
            send(4'b1111);
        end
        chk("R8 full", csr_rdata_o, 16'h00C0);
        tx_ch[2] = 8'h77;
        send(4'b0100);
        do_read("R8 first after full");
        tx_ch[3] = 8'h88;
        send(4'b1000);
        for (int k = 0; k < DEP - 1; k++) do_read("R8 drain");
        chk("R8 overrun flag", rbuf_o, 16'hC388);
        do_read("R8 flagged entry");
        tx_ch[1] = 8'h99;
        send(4'b0010);
        chk("R8 flag cleared", rbuf_o, 16'h8199);
        do_read("R8 clean entry");
        do_read("R12 empty at end");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule